// File: doc/BRIEF.md
# Multi-Source Reset Sequencer with Cause Flags

This block decides when the rest of the chip is held in reset and why. It watches four requests: a power-on reset, an active-low external reset pin, a watchdog expiry and a sleep indication from the core. Each accepted request falls into one of five kinds. The block holds a chip-wide reset until the start-up delays for that kind have run out, then releases it on a main-clock edge. Two status flags, a time-out flag and a power-down flag, record the kind so that software can read the cause after reset.

The external pin first goes through a synchroniser and then a run-length glitch filter, so short pulses never reach the sequencer. An oscillator start-up timer counts main-clock edges, and a power-up timer counts a separate slow clock. Both are 2^W-edge counters. Each timer starts only for the kinds that need it. A watchdog wake from sleep holds the core while the oscillator settles. It does not raise the general register reset, because that event resumes execution and does not restart the program.

Power-on is the asynchronous `por_n` input. It is synchronised into each clock domain before release. `wdt_timeout` and `sleeping` are synchronous to `clk_main`.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, and after it rises until release, `chip_rst` and `greg_rst` are 1, `to_flag`=1, `pd_flag`=1 and `rst_kind`=1 (power-on).
- R2: The synchronised pin must be low for at least FILT_LEN consecutive `clk_main` samples before it is accepted. A shorter low pulse leaves `chip_rst`, `rst_kind` and both flags untouched.
- R3: An accepted pin event while `sleeping`=0 sets `rst_kind`=2, raises `chip_rst` and `greg_rst`, and leaves both flags at their previous values.
- R4: An accepted pin event while `sleeping`=1 sets `rst_kind`=3, `to_flag`=1, `pd_flag`=0, and raises `chip_rst` and `greg_rst`.
- R5: `wdt_timeout` high at a clock edge with `sleeping`=0 makes `chip_rst` 1 after that same edge, with `rst_kind`=4, `to_flag`=0, `pd_flag`=1 and `greg_rst`=1.
- R6: `wdt_timeout` with `sleeping`=1 sets `rst_kind`=5, `to_flag`=0 and `pd_flag`=0, and raises `chip_rst`. `greg_rst` stays 0 for the whole event.
- R7: For kinds 1, 3 and 5, `chip_rst` falls only after the oscillator start-up timer has counted 2^OST_W `clk_main` edges. Kinds 2 and 4 wait for no timer and release within a few cycles after their source goes inactive.
- R8: For power-on with `pwrt_en`=1, `chip_rst` also waits for 2^PWRT_W `clk_slow` edges. With `pwrt_en`=0, only the start-up timer applies.
- R9: An accepted pin event wins over a `wdt_timeout` sampled at the same edge.
- R10: An accepted pin event during a start-up wait sends the sequencer back to hold and restarts the wait. The recorded kind and the flags do not change.
- R11: `greg_rst` is only ever 1 while `chip_rst` is 1. It is 1 throughout every reset kind except 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main oscillator clock; clocks the sequencer, the filter and the start-up timer |
| clk_slow | input | 1 | Independent slow clock for the power-up timer |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| ext_rst_n | input | 1 | External active-low reset pin, asynchronous |
| wdt_timeout | input | 1 | Watchdog expiry, synchronous to clk_main |
| sleeping | input | 1 | Core is in sleep, synchronous to clk_main |
| pwrt_en | input | 1 | Configuration: enable the power-up timer on power-on |
| chip_rst | output | 1 | Chip reset/hold, active high |
| greg_rst | output | 1 | General register reset enable |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |
| rst_kind | output | 3 | Kind of the last reset: 1 power-on, 2 pin run, 3 pin sleep, 4 watchdog run, 5 watchdog wake |

## Verification
The properties assume that `wdt_timeout` and `sleeping` change only away from `clk_main` rising edges. They also assume that `pwrt_en` changes only while `por_n` is low, so the power-up requirement is judged against a stable configuration. The bench drives every input on the falling edge of the main clock and changes `pwrt_en` only inside a power-on pulse. It drops `sleeping` once the event has been recognised, as a core would on leaving sleep. Random pin pulses are at least FILT_LEN cycles long when they are meant as resets and shorter when they are meant as glitches, so the expected kind is always defined.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  // Reset kind codes; values are visible on the rst_kind port.
  typedef enum logic [2:0] {
    KIND_POR      = 3'd1,
    KIND_PIN_RUN  = 3'd2,
    KIND_PIN_SLP  = 3'd3,
    KIND_WDT_RUN  = 3'd4,
    KIND_WDT_WAKE = 3'd5
  } rst_kind_e;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,  // source still active
    ST_DRAIN = 2'd1,  // timers being cleared
    ST_TIME  = 2'd2,  // timers counting
    ST_RUN   = 2'd3   // chip released
  } seq_state_e;

  // Kinds that restart the oscillator and so wait for the start-up timer.
  function automatic logic kind_needs_ost(rst_kind_e k);
    return (k == KIND_POR) || (k == KIND_PIN_SLP) || (k == KIND_WDT_WAKE);
  endfunction

endpackage

// File: rtl/rst_sync_cell.sv
module rst_sync_cell #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rst_glitch_filt.sv
module rst_glitch_filt #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_n_s,   // synchronised pin, active low
  output logic pin_low    // accepted assertion
);

  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(FILT_LEN);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic          run_en;

  // Count consecutive low samples, saturating at FILT_LEN; any high sample clears.
  always_comb begin
    run_d  = run_q;
    run_en = 1'b0;
    if (pin_n_s) begin
      run_d  = '0;
      run_en = (run_q != '0);
    end else if (run_q != RUN_MAX) begin
      run_d  = run_q + CW'(1);
      run_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign pin_low = (run_q == RUN_MAX);

endmodule

// File: rtl/rst_startup_tmr.sv
module rst_startup_tmr #(
  parameter int W = 10
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run,    // level: low clears, high counts
  output logic done    // set after 2**W counted edges
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] sum;
  logic         carry;
  logic         done_q;
  logic         done_d;
  logic         cnt_en;

  always_comb begin
    {carry, sum} = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!run) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      cnt_d  = sum;
      done_d = carry;
    end
  end

  assign cnt_en = !run || !done_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
(
  input  logic      clk,
  input  logic      arst_n,
  input  logic      pin_low,
  input  logic      wdt_hit,
  input  logic      sleeping,
  input  logic      pwrt_en,
  input  logic      ost_done,
  input  logic      pwrt_done,
  output logic      ost_run,
  output logic      pwrt_run,
  output logic      chip_rst,
  output logic      to_flag,
  output logic      pd_flag,
  output rst_kind_e kind
);

  seq_state_e st_q, st_d;
  rst_kind_e  kind_q, kind_d;
  logic       to_q, to_d, pd_q, pd_d;
  logic       chip_q, chip_d;
  logic       rst_set, rst_clr;
  logic       need_ost, need_pwrt;
  logic       timers_idle, timers_fin;

  always_comb begin
    need_ost    = kind_needs_ost(kind_q);
    need_pwrt   = (kind_q == KIND_POR) && pwrt_en;
    timers_idle = !ost_done && !pwrt_done;
    timers_fin  = (!need_ost || ost_done) && (!need_pwrt || pwrt_done);

    st_d    = st_q;
    kind_d  = kind_q;
    to_d    = to_q;
    pd_d    = pd_q;
    rst_set = 1'b0;
    rst_clr = 1'b0;

    unique case (st_q)
      ST_HOLD: begin
        if (!pin_low && !wdt_hit) st_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (pin_low)          st_d = ST_HOLD;
        else if (timers_idle) st_d = ST_TIME;
      end
      ST_TIME: begin
        if (pin_low) begin
          st_d = ST_HOLD;
        end else if (timers_fin) begin
          st_d    = ST_RUN;
          rst_clr = 1'b1;
        end
      end
      ST_RUN: begin
        // pin has priority over the watchdog
        if (pin_low) begin
          st_d    = ST_HOLD;
          rst_set = 1'b1;
          if (sleeping) begin
            kind_d = KIND_PIN_SLP;
            to_d   = 1'b1;
            pd_d   = 1'b0;
          end else begin
            kind_d = KIND_PIN_RUN;
          end
        end else if (wdt_hit) begin
          st_d    = ST_HOLD;
          rst_set = 1'b1;
          kind_d  = sleeping ? KIND_WDT_WAKE : KIND_WDT_RUN;
          to_d    = 1'b0;
          pd_d    = !sleeping;
        end
      end
      default: st_d = ST_HOLD;
    endcase

    // set-dominant SR latch for the chip reset
    chip_d = rst_set || (chip_q && !rst_clr);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= ST_HOLD;
      chip_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      chip_q <= chip_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      kind_q <= KIND_POR;
      to_q   <= 1'b1;
      pd_q   <= 1'b1;
    end else if (rst_set) begin
      kind_q <= kind_d;
      to_q   <= to_d;
      pd_q   <= pd_d;
    end
  end

  assign ost_run  = (st_q == ST_TIME) && need_ost;
  assign pwrt_run = (st_q == ST_TIME) && need_pwrt;
  assign chip_rst = chip_q;
  assign to_flag  = to_q;
  assign pd_flag  = pd_q;
  assign kind     = kind_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int OST_W       = 10,
  parameter int PWRT_W      = 10,
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_main,
  input  logic       clk_slow,
  input  logic       por_n,
  input  logic       ext_rst_n,
  input  logic       wdt_timeout,
  input  logic       sleeping,
  input  logic       pwrt_en,
  output logic       chip_rst,
  output logic       greg_rst,
  output logic       to_flag,
  output logic       pd_flag,
  output logic [2:0] rst_kind
);

  localparam int N_DOM = 2;  // index 0: slow domain, 1: main domain

  logic [N_DOM-1:0] dom_clk;
  logic [N_DOM-1:0] dom_rst_n;
  logic             rst_n_main;
  logic             rst_n_slow;
  logic             ext_n_s;
  logic             pin_low;
  logic             ost_run;
  logic             ost_done;
  logic             pwrt_run;
  logic             pwrt_run_s;
  logic             pwrt_done_s;
  logic             pwrt_done_m;
  rst_kind_e        kind;

  assign dom_clk = {clk_main, clk_slow};

  // power-on reset: asynchronous assert, synchronous release per domain
  for (genvar d = 0; d < N_DOM; d++) begin : g_rst_sync
    rst_sync_cell #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rsync (
      .clk    (dom_clk[d]),
      .arst_n (por_n),
      .d      (1'b1),
      .q      (dom_rst_n[d])
    );
  end

  assign rst_n_slow = dom_rst_n[0];
  assign rst_n_main = dom_rst_n[1];

  rst_sync_cell #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk    (clk_main),
    .arst_n (rst_n_main),
    .d      (ext_rst_n),
    .q      (ext_n_s)
  );

  rst_glitch_filt #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk     (clk_main),
    .arst_n  (rst_n_main),
    .pin_n_s (ext_n_s),
    .pin_low (pin_low)
  );

  rst_startup_tmr #(.W(OST_W)) u_ost (
    .clk    (clk_main),
    .arst_n (rst_n_main),
    .run    (ost_run),
    .done   (ost_done)
  );

  rst_sync_cell #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pwrt_req_sync (
    .clk    (clk_slow),
    .arst_n (rst_n_slow),
    .d      (pwrt_run),
    .q      (pwrt_run_s)
  );

  rst_startup_tmr #(.W(PWRT_W)) u_pwrt (
    .clk    (clk_slow),
    .arst_n (rst_n_slow),
    .run    (pwrt_run_s),
    .done   (pwrt_done_s)
  );

  rst_sync_cell #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pwrt_done_sync (
    .clk    (clk_main),
    .arst_n (rst_n_main),
    .d      (pwrt_done_s),
    .q      (pwrt_done_m)
  );

  rst_seq_fsm u_fsm (
    .clk       (clk_main),
    .arst_n    (rst_n_main),
    .pin_low   (pin_low),
    .wdt_hit   (wdt_timeout),
    .sleeping  (sleeping),
    .pwrt_en   (pwrt_en),
    .ost_done  (ost_done),
    .pwrt_done (pwrt_done_m),
    .ost_run   (ost_run),
    .pwrt_run  (pwrt_run),
    .chip_rst  (chip_rst),
    .to_flag   (to_flag),
    .pd_flag   (pd_flag),
    .kind      (kind)
  );

  assign rst_kind = kind;
  assign greg_rst = chip_rst && (kind != KIND_WDT_WAKE);

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk
  import rst_seq_pkg::*;
(
  input logic       clk_main,
  input logic       rst_n_main,
  input logic       chip_rst,
  input logic       greg_rst,
  input logic       to_flag,
  input logic       pd_flag,
  input logic [2:0] rst_kind,
  input logic       pin_low,
  input logic       wdt_timeout,
  input logic       pwrt_en,
  input logic       ost_done,
  input logic       pwrt_done_m
);

  assert_por_flags_R1: assert property (@(posedge clk_main) disable iff (!rst_n_main)
    (rst_kind == KIND_POR) |-> (to_flag && pd_flag));

  assert_set_cause_R2: assert property (@(posedge clk_main) disable iff (!rst_n_main)
    $rose(chip_rst) |-> $past(pin_low || wdt_timeout));

  assert_pin_run_flags_R3: assert property (@(posedge clk_main) disable iff (!rst_n_main)
    ($rose(chip_rst) && rst_kind == KIND_PIN_RUN) |-> ($stable(to_flag) && $stable(pd_flag)));

  assert_pin_sleep_flags_R4: assert property (@(posedge clk_main) disable iff (!rst_n_main)
    (chip_rst && rst_kind == KIND_PIN_SLP) |-> (to_flag && !pd_flag));

  assert_wdt_run_flags_R5: assert property (@(posedge clk_main) disable iff (!rst_n_main)
    (chip_rst && rst_kind == KIND_WDT_RUN) |-> (!to_flag && pd_flag));

  assert_wake_flags_R6: assert property (@(posedge clk_main) disable iff (!rst_n_main)
    (rst_kind == KIND_WDT_WAKE) |-> (!greg_rst && !to_flag && !pd_flag));

  assert_ost_release_R7: assert property (@(posedge clk_main) disable iff (!rst_n_main)
    ($fell(chip_rst) && (rst_kind == KIND_POR || rst_kind == KIND_PIN_SLP ||
                         rst_kind == KIND_WDT_WAKE)) |-> $past(ost_done));

  assert_pwrt_release_R8: assert property (@(posedge clk_main) disable iff (!rst_n_main)
    ($fell(chip_rst) && rst_kind == KIND_POR && pwrt_en) |-> $past(pwrt_done_m));

  assert_pin_priority_R9: assert property (@(posedge clk_main) disable iff (!rst_n_main)
    ($rose(chip_rst) && $past(pin_low)) |->
      (rst_kind == KIND_PIN_RUN || rst_kind == KIND_PIN_SLP));

  assert_greg_inside_chip_R11: assert property (@(posedge clk_main) disable iff (!rst_n_main)
    greg_rst |-> chip_rst);

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk u_chk (
  .clk_main    (clk_main),
  .rst_n_main  (rst_n_main),
  .chip_rst    (chip_rst),
  .greg_rst    (greg_rst),
  .to_flag     (to_flag),
  .pd_flag     (pd_flag),
  .rst_kind    (rst_kind),
  .pin_low     (pin_low),
  .wdt_timeout (wdt_timeout),
  .pwrt_en     (pwrt_en),
  .ost_done    (ost_done),
  .pwrt_done_m (pwrt_done_m)
);

// File: tb/rst_seq_ctrl_bench.sv
module rst_seq_ctrl_bench;

  localparam int OST_W       = 10;
  localparam int PWRT_W      = 10;
  localparam int FILT_LEN    = 4;
  localparam int SYNC_STAGES = 2;
  localparam int SLOW_RATIO  = 8;
  localparam int OST_CYC     = 1 << OST_W;
  localparam int PWRT_CYC    = (1 << PWRT_W) * SLOW_RATIO;

  logic       clk_main = 1'b0;
  logic       clk_slow = 1'b0;
  logic       por_n, ext_rst_n, wdt_timeout, sleeping, pwrt_en;
  logic       chip_rst, greg_rst, to_flag, pd_flag;
  logic [2:0] rst_kind;

  always #2  clk_main = ~clk_main;
  always #16 clk_slow = ~clk_slow;

  rst_seq_ctrl #(.OST_W(OST_W), .PWRT_W(PWRT_W), .FILT_LEN(FILT_LEN),
                 .SYNC_STAGES(SYNC_STAGES)) u_rst_seq_ctrl (
    .clk_main(clk_main), .clk_slow(clk_slow), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .wdt_timeout(wdt_timeout), .sleeping(sleeping), .pwrt_en(pwrt_en),
    .chip_rst(chip_rst), .greg_rst(greg_rst), .to_flag(to_flag), .pd_flag(pd_flag),
    .rst_kind(rst_kind)
  );

  int total = 0;
  int bad   = 0;
  logic [1:0] exp_fl;   // {to, pd}
  int         exp_k;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic int exp_kind(input bit use_pin, input bit slp);
    if (use_pin) return slp ? 3 : 2;
    return slp ? 5 : 4;
  endfunction

  function automatic logic [1:0] exp_flags(input int k, input logic [1:0] prev);
    case (k)
      1: return 2'b11;
      3: return 2'b10;
      4: return 2'b01;
      5: return 2'b00;
      default: return prev;
    endcase
  endfunction

  function automatic bit kind_waits(input int k);
    return (k == 1) || (k == 3) || (k == 5);
  endfunction

  task automatic count_release(output int rel, inout bit seen_greg);
    rel = 0;
    while (chip_rst && rel < 20000) begin
      @(negedge clk_main);
      rel++;
      seen_greg |= greg_rst;
    end
  endtask

  task automatic event_run(input bit use_pin, input bit slp, input int pin_len,
                           output bit first_hi, output bit seen, output bit seen_greg,
                           output int rel);
    sleeping = slp;
    @(negedge clk_main);
    seen = 1'b0; seen_greg = 1'b0; first_hi = 1'b0;
    if (use_pin) begin
      ext_rst_n = 1'b0;
      for (int i = 0; i < pin_len; i++) begin
        @(negedge clk_main);
        seen |= chip_rst; seen_greg |= greg_rst;
      end
      ext_rst_n = 1'b1;
      for (int i = 0; i < SYNC_STAGES + 2; i++) begin
        @(negedge clk_main);
        seen |= chip_rst; seen_greg |= greg_rst;
      end
    end else begin
      wdt_timeout = 1'b1;
      @(negedge clk_main);
      first_hi = chip_rst; seen = chip_rst; seen_greg = greg_rst;
      wdt_timeout = 1'b0;
    end
    sleeping = 1'b0;
    count_release(rel, seen_greg);
    repeat (3) @(negedge clk_main);
  endtask

  task automatic check_event(input string tag, input int k, input bit seen, input bit sg,
                             input int rel);
    check({tag, " kind"}, int'(rst_kind), k);
    check({tag, " to_flag"}, int'(to_flag), int'(exp_flags(k, exp_fl) >> 1));
    check({tag, " pd_flag"}, int'(pd_flag), int'(exp_flags(k, exp_fl) & 2'b01));
    check({tag, " chip_rst seen"}, int'(seen), 1);
    check({tag, " R11 greg_rst seen"}, int'(sg), (k == 5) ? 0 : 1);
    if (kind_waits(k)) check_range({tag, " R7 release latency"}, rel, OST_CYC - 16, OST_CYC + 64);
    else               check_range({tag, " R7 release latency"}, rel, 0, 16);
    exp_fl = exp_flags(k, exp_fl);
    exp_k  = k;
  endtask

  initial begin
    repeat (150000) @(posedge clk_main);
    total++; bad++;
    $display("FAIL WDOG: run did not finish, actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit fh, sn, sg;
    int rel;
    void'($urandom(32'd7741));
    por_n = 1'b0; ext_rst_n = 1'b1; wdt_timeout = 1'b0; sleeping = 1'b0; pwrt_en = 1'b1;
    repeat (5) @(negedge clk_main);

    // R1: reset state
    check("R1 chip_rst in reset", int'(chip_rst), 1);
    check("R1 greg_rst in reset", int'(greg_rst), 1);
    check("R1 to_flag", int'(to_flag), 1);
    check("R1 pd_flag", int'(pd_flag), 1);
    check("R1 kind", int'(rst_kind), 1);

    // R8: power-up timer on power-on
    por_n = 1'b1;
    sg = 1'b0;
    count_release(rel, sg);
    check_range("R8 power-up release latency", rel, PWRT_CYC, PWRT_CYC + 400);
    check("R1 greg_rst held through power-on", int'(sg), 1);
    check("R1 flags after release", int'({to_flag, pd_flag}), 3);

    // R7/R8: power-on without the power-up timer
    por_n = 1'b0; pwrt_en = 1'b0;
    repeat (3) @(negedge clk_main);
    por_n = 1'b1;
    sg = 1'b0;
    count_release(rel, sg);
    check_range("R7 R8 start-up only latency", rel, OST_CYC, OST_CYC + 40);
    exp_fl = 2'b11; exp_k = 1;
    repeat (3) @(negedge clk_main);

    // R5: watchdog in run
    event_run(1'b0, 1'b0, 0, fh, sn, sg, rel);
    check("R5 chip_rst after the sampling edge", int'(fh), 1);
    check_event("R5", 4, sn, sg, rel);

    // R2: short glitch ignored
    event_run(1'b1, 1'b0, FILT_LEN - 1, fh, sn, sg, rel);
    check("R2 glitch chip_rst", int'(sn), 0);
    check("R2 glitch kind", int'(rst_kind), exp_k);
    check("R2 glitch flags", int'({to_flag, pd_flag}), int'(exp_fl));

    // R2/R3: minimum accepted width in run
    event_run(1'b1, 1'b0, FILT_LEN, fh, sn, sg, rel);
    check_event("R2 R3", 2, sn, sg, rel);

    // R6: watchdog wake from sleep
    event_run(1'b0, 1'b1, 0, fh, sn, sg, rel);
    check("R6 chip_rst after the sampling edge", int'(fh), 1);
    check_event("R6", 5, sn, sg, rel);

    // R4: pin during sleep
    event_run(1'b1, 1'b1, 8, fh, sn, sg, rel);
    check_event("R4", 3, sn, sg, rel);

    // R9: pin accepted at the same edge as a watchdog expiry
    @(negedge clk_main);
    ext_rst_n = 1'b0;
    repeat (SYNC_STAGES + FILT_LEN) @(negedge clk_main);
    wdt_timeout = 1'b1;
    repeat (2) @(negedge clk_main);
    wdt_timeout = 1'b0;
    repeat (2) @(negedge clk_main);
    ext_rst_n = 1'b1;
    repeat (SYNC_STAGES + 2) @(negedge clk_main);
    sg = 1'b0;
    count_release(rel, sg);
    check("R9 kind is pin run", int'(rst_kind), 2);
    check("R9 flags unchanged", int'({to_flag, pd_flag}), int'(exp_fl));
    exp_k = 2;

    // R10: pin during the start-up wait of a wake
    sleeping = 1'b1;
    @(negedge clk_main);
    wdt_timeout = 1'b1;
    @(negedge clk_main);
    wdt_timeout = 1'b0; sleeping = 1'b0;
    repeat (200) @(negedge clk_main);
    check("R10 still held mid-wait", int'(chip_rst), 1);
    ext_rst_n = 1'b0;
    repeat (8) @(negedge clk_main);
    ext_rst_n = 1'b1;
    sg = 1'b0;
    count_release(rel, sg);
    check_range("R10 wait restarted", rel, OST_CYC, OST_CYC + 40);
    check("R10 kind unchanged", int'(rst_kind), 5);
    check("R10 flags unchanged", int'({to_flag, pd_flag}), 0);
    check("R10 R6 greg_rst never", int'(sg), 0);
    exp_fl = 2'b00; exp_k = 5;
    repeat (3) @(negedge clk_main);

    // random mix
    for (int it = 0; it < 24; it++) begin
      bit up, sl;
      int k;
      up = 1'($urandom % 2);
      sl = 1'($urandom % 2);
      if (($urandom % 3) == 0) begin
        event_run(1'b1, 1'b0, 1 + int'($urandom % (FILT_LEN - 1)), fh, sn, sg, rel);
        check("R2 random glitch ignored", int'(sn), 0);
        check("R2 random glitch kind", int'(rst_kind), exp_k);
      end
      k = exp_kind(up, sl);
      event_run(up, sl, FILT_LEN + int'($urandom % 6), fh, sn, sg, rel);
      check_event("R3 R4 R5 R6 random", k, sn, sg, rel);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule